// File: doc/BRIEF.md
# Shadowed Position Compare Pulse Generator

The block compares a position count, sampled every system clock, with an active compare value. When the count first becomes equal to that value while compare is enabled, the block gives a one-cycle match event. It also starts a sync pulse whose width and level are programmable. The pulse can be routed to one of two pins. The block only reports which pin through a select output, together with an output-enable.

The compare value is written through a simple write strobe. Software can write it straight into the active register. It can instead write it into a shadow register that is copied into the active register later, either when the count reaches zero or when the count matches the current active value. Each copy gives a one-cycle ready event. Control bits arrive through a second write strobe. They take effect on the clock edge that captures them.

Control word layout (`ctl_wdata_i`): bits 11:0 pulse-width field, bit 12 compare enable, bit 13 shadow enable, bit 14 shadow load select, bit 15 polarity, bit 16 sync output enable, bit 17 pin select.

Top module: `pcmp_sync_gen`

## Requirements
- R1: After reset the active compare value is 0, the control word is 0, `sync_o`, `match_o`, `ready_o`, `sync_oe_o` and `pin_sel_o` are all 0.
- R2: With shadow enable (control bit 13) at 0, a compare write sets `active_cmp_o` to the written value on the next cycle. A direct write takes priority over a pending shadow copy in the same cycle, and it cancels that copy.
- R3: With shadow enable at 1, a compare write leaves `active_cmp_o` unchanged until a shadow copy happens.
- R4: With load select (bit 14) at 0, compare enabled (bit 12) and a shadow value pending, a cycle in which `pos_i` is 0 copies the shadow into `active_cmp_o`. `ready_o` is high for one cycle, in the cycle after that sample.
- R5: With load select at 1, the copy happens in a cycle in which `pos_i` equals the current active value. The match event for that cycle is still raised against the old value.
- R6: With compare enabled, `match_o` is high for exactly one cycle, the cycle after `pos_i` becomes equal to the active value. This applies after any cycle in which it was not equal.
- R7: A match starts a sync pulse lasting (width field + 1) × 4 clocks. The pulse begins in the same cycle as `match_o`.
- R8: Polarity bit 15 at 0 gives an active-high pulse on an idle-low line. At 1 it gives an active-low pulse on an idle-high line.
- R9: `sync_oe_o` follows bit 16 and `pin_sel_o` follows bit 17 (0 selects index, 1 selects strobe). While bit 16 is 0, `sync_o` stays at its inactive level.
- R10: A match during an active pulse restarts the full pulse width from that match.
- R11: With compare disabled, neither `match_o` nor `ready_o` is raised, no shadow copy happens, and `sync_o` is at its inactive level from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pos_i | input | 32 | Position count to compare |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | 32 | Compare value write data |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 18 | Control word write data |
| sync_o | output | 1 | Sync pulse, polarity applied |
| sync_oe_o | output | 1 | Sync output enable |
| pin_sel_o | output | 1 | Pin select: 0 index, 1 strobe |
| match_o | output | 1 | One-cycle compare match event |
| ready_o | output | 1 | One-cycle shadow copy event |
| active_cmp_o | output | 32 | Current active compare value |

## Verification
The hardest situations to reach are those where two events collide in one cycle. One is a shadow copy at match, where the match must still be judged against the old value. Another is a compare write that lands while a copy is pending. A third is a second match that arrives while a pulse is still running. Directed sequences build each of these collisions on purpose. A long random phase then keeps `pos_i` mostly on 0, on the active value, or next to it, with frequent writes, so that these collisions keep recurring under changing control settings. A per-cycle reference model checks every output in that phase.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
   localparam int WIDTH_FLD_W = 12;
   localparam int CTL_W       = WIDTH_FLD_W + 6;

   typedef struct packed {
      logic                   pin_sel;   // bit 17
      logic                   out_en;    // bit 16
      logic                   act_low;   // bit 15
      logic                   load_at_match; // bit 14
      logic                   shadow_en; // bit 13
      logic                   cmp_en;    // bit 12
      logic [WIDTH_FLD_W-1:0] width;     // bits 11:0
   } pcmp_ctl_t;
endpackage

// File: rtl/pcmp_cmp_reg.sv
module pcmp_cmp_reg #(
   parameter int POS_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cmp_en_i,
   input  logic             shadow_en_i,
   input  logic             load_at_match_i,
   input  logic             we_i,
   input  logic [POS_W-1:0] wdata_i,
   input  logic [POS_W-1:0] pos_i,
   output logic [POS_W-1:0] active_o,
   output logic             ready_o
);
   logic [POS_W-1:0] shadow_q;
   logic             pend_q;
   logic             direct_wr, shadow_wr, load_hit, xfer;

   assign direct_wr = we_i & ~shadow_en_i;
   assign shadow_wr = we_i & shadow_en_i;
   assign load_hit  = load_at_match_i ? (pos_i == active_o) : (pos_i == '0);
   assign xfer      = cmp_en_i & pend_q & load_hit & ~direct_wr;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_o <= '0;
         shadow_q <= '0;
         pend_q   <= 1'b0;
         ready_o  <= 1'b0;
      end else begin
         ready_o <= xfer;
         if (direct_wr) begin
            active_o <= wdata_i;
            pend_q   <= 1'b0;
         end else begin
            if (xfer)      active_o <= shadow_q;
            if (shadow_wr) shadow_q <= wdata_i;
            pend_q <= (pend_q & ~xfer) | shadow_wr;
         end
      end
   end

   p_direct_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      direct_wr |=> (active_o == $past(wdata_i)));
   p_shadow_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!direct_wr && !xfer) |=> $stable(active_o));
   p_ready_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xfer |=> (ready_o && active_o == $past(shadow_q)));
   p_no_copy_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmp_en_i |=> !ready_o);
endmodule

// File: rtl/pcmp_match_det.sv
module pcmp_match_det #(
   parameter int POS_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cmp_en_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic [POS_W-1:0] active_i,
   output logic             trig_o,
   output logic             match_o
);
   logic eq, eq_q;

   assign eq     = cmp_en_i & (pos_i == active_i);
   assign trig_o = eq & ~eq_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         eq_q    <= 1'b0;
         match_o <= 1'b0;
      end else begin
         eq_q    <= eq;
         match_o <= trig_o;
      end
   end

   p_match_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o |=> !match_o);
   p_no_match_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmp_en_i |=> !match_o);
endmodule

// File: rtl/pcmp_pulse_stretch.sv
module pcmp_pulse_stretch #(
   parameter int WID_W     = 12,
   parameter int UNIT_CLKS = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             trig_i,
   input  logic [WID_W-1:0] width_i,
   output logic             active_o
);
   localparam int MAX_LEN = (2 ** WID_W) * UNIT_CLKS;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);
   localparam bit UNIT_P2 = (UNIT_CLKS & (UNIT_CLKS - 1)) == 0;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len;
   logic [CNT_W-1:0] units;

   assign units = CNT_W'(width_i) + CNT_W'(1);

   generate
      if (UNIT_CLKS < 1) begin : g_bad_unit
         $error("UNIT_CLKS must be at least 1");
      end
      if (WID_W < 1) begin : g_bad_wid
         $error("WID_W must be at least 1");
      end
      if (UNIT_P2) begin : g_shift
         assign len = units << $clog2(UNIT_CLKS);
      end else begin : g_mult
         assign len = units * CNT_W'(UNIT_CLKS);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (!en_i)        cnt_q <= '0;
      else if (trig_i)       cnt_q <= len;
      else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
   end

   assign active_o = (cnt_q != '0);

   p_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && trig_i) |=> active_o);
   p_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cnt_q > CNT_W'(1)) |=> active_o);
   p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && trig_i && active_o) |=> (cnt_q >= CNT_W'(UNIT_CLKS)));
   p_idle_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !active_o);
endmodule

// File: rtl/pcmp_sync_gen.sv
module pcmp_sync_gen
   import pcmp_pkg::*;
#(
   parameter int POS_W     = 32,
   parameter int UNIT_CLKS = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [POS_W-1:0] pos_i,
   input  logic             cmp_we_i,
   input  logic [POS_W-1:0] cmp_wdata_i,
   input  logic             ctl_we_i,
   input  logic [CTL_W-1:0] ctl_wdata_i,
   output logic             sync_o,
   output logic             sync_oe_o,
   output logic             pin_sel_o,
   output logic             match_o,
   output logic             ready_o,
   output logic [POS_W-1:0] active_cmp_o
);
   pcmp_ctl_t ctl_q;
   logic      trig, pulse_on;

   generate
      if (POS_W < 2) begin : g_bad_pos
         $error("POS_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ctl_q <= '0;
      else if (ctl_we_i) ctl_q <= pcmp_ctl_t'(ctl_wdata_i);
   end

   pcmp_cmp_reg #(.POS_W(POS_W)) u_cmp_reg (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .cmp_en_i        (ctl_q.cmp_en),
      .shadow_en_i     (ctl_q.shadow_en),
      .load_at_match_i (ctl_q.load_at_match),
      .we_i            (cmp_we_i),
      .wdata_i         (cmp_wdata_i),
      .pos_i           (pos_i),
      .active_o        (active_cmp_o),
      .ready_o         (ready_o)
   );

   pcmp_match_det #(.POS_W(POS_W)) u_match (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmp_en_i (ctl_q.cmp_en),
      .pos_i    (pos_i),
      .active_i (active_cmp_o),
      .trig_o   (trig),
      .match_o  (match_o)
   );

   pcmp_pulse_stretch #(.WID_W(WIDTH_FLD_W), .UNIT_CLKS(UNIT_CLKS)) u_pulse (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (ctl_q.cmp_en),
      .trig_i   (trig),
      .width_i  (ctl_q.width),
      .active_o (pulse_on)
   );

   assign sync_o    = ctl_q.act_low ^ (pulse_on & ctl_q.out_en);
   assign sync_oe_o = ctl_q.out_en;
   assign pin_sel_o = ctl_q.pin_sel;

   p_match_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_o && ctl_q.out_en && !ctl_q.act_low) |-> sync_o);
   p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sync_oe_o |-> (sync_o == ctl_q.act_low));
endmodule

// File: tb/pcmp_sync_gen_tb.sv
module pcmp_sync_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pos = '0;
   logic        cwe = 1'b0;
   logic [31:0] cdat = '0;
   logic        twe = 1'b0;
   logic [17:0] tdat = '0;
   logic        sync_o, sync_oe_o, pin_sel_o, match_o, ready_o;
   logic [31:0] active_cmp_o;

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   logic [31:0] m_act, m_sh;
   logic        m_pend, m_eqq, m_match, m_ready;
   int          m_cnt;
   logic [17:0] m_ctl;

   always #5ns clk = ~clk;

   pcmp_sync_gen dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pos_i(pos),
      .cmp_we_i(cwe), .cmp_wdata_i(cdat),
      .ctl_we_i(twe), .ctl_wdata_i(tdat),
      .sync_o(sync_o), .sync_oe_o(sync_oe_o), .pin_sel_o(pin_sel_o),
      .match_o(match_o), .ready_o(ready_o), .active_cmp_o(active_cmp_o)
   );

   function automatic logic [17:0] mk_ctl(input logic en, input logic sh, input logic lm,
                                          input logic pol, input logic oe, input logic ps,
                                          input logic [11:0] w);
      return {ps, oe, pol, lm, sh, en, w};
   endfunction

   function automatic logic exp_sync();
      return m_ctl[15] ^ ((m_cnt != 0) & m_ctl[16]);
   endfunction

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_act = '0; m_sh = '0; m_pend = 0; m_eqq = 0; m_match = 0; m_ready = 0;
      m_cnt = 0; m_ctl = '0;
   endtask

   task automatic model_step(input logic [31:0] p, input logic wc, input logic [31:0] cd,
                             input logic wt, input logic [17:0] td);
      logic en, sh, lm, eq, hit, dir, xf, tr;
      en  = m_ctl[12]; sh = m_ctl[13]; lm = m_ctl[14];
      eq  = en && (p == m_act);
      hit = lm ? (p == m_act) : (p == 0);
      dir = wc && !sh;
      xf  = en && m_pend && hit && !dir;
      tr  = eq && !m_eqq;
      m_ready = xf;
      m_match = tr;
      m_eqq   = eq;
      if (!en)          m_cnt = 0;
      else if (tr)      m_cnt = (int'(m_ctl[11:0]) + 1) * 4;
      else if (m_cnt>0) m_cnt = m_cnt - 1;
      if (dir) begin
         m_act = cd; m_pend = 0;
      end else begin
         if (xf) m_act = m_sh;
         m_pend = (m_pend && !xf) || (wc && sh);
         if (wc && sh) m_sh = cd;
      end
      if (wt) m_ctl = td;
   endtask

   task automatic compare_all();
      chk(sync_o == exp_sync(), "R7 sync_o model", 32'(sync_o), 32'(exp_sync()));
      chk(match_o == m_match, "R6 match_o model", 32'(match_o), 32'(m_match));
      chk(ready_o == m_ready, "R4 ready_o model", 32'(ready_o), 32'(m_ready));
      chk(active_cmp_o == m_act, "R2 active_cmp_o model", active_cmp_o, m_act);
      chk(sync_oe_o == m_ctl[16] && pin_sel_o == m_ctl[17], "R9 oe/pin model",
          {30'd0, pin_sel_o, sync_oe_o}, {30'd0, m_ctl[17], m_ctl[16]});
   endtask

   // one clock: check at negedge, drive, capture, advance model
   task automatic cyc(input logic [31:0] p, input logic wc = 0, input logic [31:0] cd = 0,
                      input logic wt = 0, input logic [17:0] td = 0);
      compare_all();
      pos = p; cwe = wc; cdat = cd; twe = wt; tdat = td;
      @(posedge clk);
      model_step(p, wc, cd, wt, td);
      @(negedge clk);
      cwe = 0; twe = 0;
   endtask

   // runs n cycles at position p and counts cycles with the pulse asserted
   task automatic count_on(input logic [31:0] p, input int n, input logic pol, inout int hi);
      for (int i = 0; i < n; i++) begin
         cyc(p);
         if (sync_o != pol) hi++;
      end
   endtask

   initial begin
      int hi;
      int seed;
      logic [31:0] rp;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({sync_o, match_o, ready_o, sync_oe_o, pin_sel_o} == 5'b0, "R1 reset outputs",
          {27'd0, sync_o, match_o, ready_o, sync_oe_o, pin_sel_o}, 0);
      chk(active_cmp_o == 0, "R1 reset compare", active_cmp_o, 0);

      // R2 immediate write
      cyc(100, 0, 0, 1, mk_ctl(1, 0, 0, 0, 1, 0, 12'd0));
      cyc(100, 1, 5);
      chk(active_cmp_o == 5, "R2 immediate write", active_cmp_o, 5);

      // R6 / R7 width field 0 gives 4 clocks
      cyc(5);
      chk(match_o == 1, "R6 match event", 32'(match_o), 1);
      hi = (sync_o != 0) ? 1 : 0;
      count_on(6, 9, 0, hi);
      chk(hi == 4, "R7 width 0", hi, 4);

      // R7 width field 2 gives 12 clocks
      cyc(100, 0, 0, 1, mk_ctl(1, 0, 0, 0, 1, 0, 12'd2));
      cyc(5);
      hi = (sync_o != 0) ? 1 : 0;
      count_on(6, 20, 0, hi);
      chk(hi == 12, "R7 width 2", hi, 12);

      // R8 active-low
      cyc(100, 0, 0, 1, mk_ctl(1, 0, 0, 1, 1, 0, 12'd0));
      chk(sync_o == 1, "R8 idle high", 32'(sync_o), 1);
      cyc(5);
      chk(sync_o == 0, "R8 active low pulse", 32'(sync_o), 0);
      count_on(6, 6, 1, hi);

      // R9 output enable off, strobe pin selected
      cyc(100, 0, 0, 1, mk_ctl(1, 0, 0, 0, 0, 1, 12'd0));
      chk(sync_oe_o == 0 && pin_sel_o == 1, "R9 oe/pin", {30'd0, pin_sel_o, sync_oe_o}, 2);
      cyc(5);
      chk(sync_o == 0 && match_o == 1, "R9 gated pulse", {30'd0, match_o, sync_o}, 2);
      count_on(6, 6, 0, hi);

      // R10 retrigger during pulse
      cyc(100, 0, 0, 1, mk_ctl(1, 0, 0, 0, 1, 0, 12'd0));
      cyc(5);
      hi = (sync_o != 0) ? 1 : 0;
      count_on(6, 2, 0, hi);
      count_on(5, 1, 0, hi);
      count_on(6, 10, 0, hi);
      chk(hi == 7, "R10 restart", hi, 7);

      // R3 / R4 shadow with load at zero
      cyc(100, 0, 0, 1, mk_ctl(1, 1, 0, 0, 1, 0, 12'd0));
      cyc(3, 1, 9);
      cyc(3);
      chk(active_cmp_o == 5, "R3 shadow held", active_cmp_o, 5);
      cyc(0);
      chk(ready_o == 1 && active_cmp_o == 9, "R4 copy at zero", active_cmp_o, 9);
      cyc(0);
      chk(ready_o == 0, "R4 ready one cycle", 32'(ready_o), 0);

      // R5 load at match
      cyc(100, 0, 0, 1, mk_ctl(1, 1, 1, 0, 1, 0, 12'd0));
      cyc(0, 1, 12);
      cyc(0);
      chk(active_cmp_o == 9 && ready_o == 0, "R5 no copy at zero", active_cmp_o, 9);
      cyc(9);
      chk(ready_o && match_o && active_cmp_o == 12, "R5 copy at match", active_cmp_o, 12);
      count_on(6, 6, 0, hi);

      // R2 direct write cancels a pending copy
      cyc(100, 1, 20);
      cyc(100, 0, 0, 1, mk_ctl(1, 0, 1, 0, 1, 0, 12'd0));
      cyc(12, 1, 30);
      chk(active_cmp_o == 30 && ready_o == 0, "R2 direct wins", active_cmp_o, 30);

      // R11 disabled compare
      cyc(100, 0, 0, 1, mk_ctl(0, 1, 0, 0, 1, 0, 12'd0));
      cyc(0, 1, 40);
      cyc(30);
      cyc(0);
      chk(!match_o && !ready_o && !sync_o && active_cmp_o == 30, "R11 disabled",
          {29'd0, match_o, ready_o, sync_o}, 0);

      // random phase, fixed seed
      seed = 32'd1357;
      void'($urandom(seed));
      for (int k = 0; k < 4000; k++) begin
         logic wc, wt;
         logic [31:0] cd;
         logic [17:0] td;
         case ($urandom % 8)
            0:       rp = 0;
            1, 2, 3: rp = m_act;
            4:       rp = m_act + 1;
            default: rp = $urandom % 16;
         endcase
         wc = ($urandom % 10) == 0;
         cd = $urandom % 16;
         wt = ($urandom % 25) == 0;
         td = mk_ctl(($urandom % 5) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), 12'($urandom % 4));
         cyc(rp, wc, cd, wt, td);
      end
      compare_all();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1ms;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule